// File: doc/BRIEF.md
# Speculative Load/Store Alias Detector

This block lets a scheduler hoist loads above older stores, or drop a repeated load, when it cannot prove beforehand that the addresses never overlap. A speculative load presents a protect request with its byte address and access size. The block records that byte range as a guarded region in a small table. Later, a store that was marked for checking presents its own address and size. The block compares that range against every guarded region. If any byte is shared, it raises an alias fault so that the surrounding machinery can undo the speculation.

The table is emptied when the speculative window ends, either by a commit or by a rollback. The table has a fixed capacity. When it is full, a further protect request replaces the oldest region. Replacing a region loses coverage, so a sticky overflow flag is also set, and it makes the next checked store fault whatever its address. Stores that were not marked for checking are never compared.

Top module: `spec_alias_guard`

## Requirements
- R1: After reset the table is empty and `alias_fault` is low, so a checked store faults only if a protect request was accepted after reset.
- R2: A protect request with address A and size code S records the byte range A to A+2^S-1. The size codes are 0 for 1 byte, 1 for 2 bytes, 2 for 4 bytes and 3 for 8 bytes.
- R3: A checked store whose byte range shares at least one byte with a valid region, including a partial overlap, drives `alias_fault` high for exactly the cycle after the edge that sampled the store.
- R4: A checked store whose range only touches a region's edge, ending just below it or starting just above it, does not fault.
- R5: When `chk_valid` is low, `alias_fault` stays low on the next cycle, whatever is on the store address and size inputs.
- R6: `commit` invalidates every region and clears the overflow flag.
- R7: `rollback` invalidates every region and clears the overflow flag.
- R8: The table holds ENTRIES regions (8 by default) without loss. A protect request while the table is full replaces the oldest region, and that region no longer faults.
- R9: A protect request that replaces a region sets a sticky overflow flag. The next checked store then faults whatever its address, and that store clears the flag.
- R10: When a protect request and a checked store arrive in the same cycle, the store is compared only with regions that already existed before that cycle.
- R11: A commit or rollback discards a protect request in the same cycle. A checked store in the same cycle is still compared with the table as it stood before the clear.
- R12: Regions do not wrap past the top of the address space. A range that extends beyond the highest address does not cover the lowest addresses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prot_valid | input | 1 | Protect request from a speculative load |
| prot_addr | input | ADDR_W | Byte address of the protected load |
| prot_size | input | 2 | Size code of the load (0..3 means 1, 2, 4 or 8 bytes) |
| chk_valid | input | 1 | Checked-store request |
| chk_addr | input | ADDR_W | Byte address of the checked store |
| chk_size | input | 2 | Size code of the store |
| commit | input | 1 | End of the speculative window; empties the table |
| rollback | input | 1 | Abort of the speculative window; empties the table |
| alias_fault | output | 1 | Registered fault pulse for a checked store |

## Verification
Each checked store, or each idle cycle, produces its verdict on `alias_fault` one edge later. A protect, commit or rollback affects only checked stores sampled on later edges. The driver applies one request set per cycle at the falling edge and queues the fault value expected after the next rising edge. The monitor samples shortly after that rising edge and compares against the head of the queue. Each verdict is therefore checked in the exact cycle it is due, and a stray pulse on an idle cycle is caught as a mismatch.

// File: rtl/alias_guard_pkg.sv
package alias_guard_pkg;

  typedef logic [1:0] size_code_t;

  // last byte offset of an access: 2^code - 1
  function automatic logic [3:0] span_last(input size_code_t code);
    logic [3:0] r;
    case (code)
      2'd0:    r = 4'd0;
      2'd1:    r = 4'd1;
      2'd2:    r = 4'd3;
      default: r = 4'd7;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/guard_region_table.sv
module guard_region_table
  import alias_guard_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int ENTRIES = 8,
  localparam int EXT_W  = ADDR_W + 1,
  localparam int PTR_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int CNT_W  = $clog2(ENTRIES + 1)
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           wr_en,
  input  logic [ADDR_W-1:0]              wr_addr,
  input  size_code_t                     wr_size,
  input  logic                           clr,
  output logic [ENTRIES-1:0]             valid_o,
  output logic [ENTRIES-1:0][EXT_W-1:0]  base_o,
  output logic [ENTRIES-1:0][EXT_W-1:0]  last_o,
  output logic                           evict_o
);

  logic [ENTRIES-1:0][EXT_W-1:0] base_q;
  logic [ENTRIES-1:0][EXT_W-1:0] last_q;
  logic [ENTRIES-1:0]            valid_q;
  logic [PTR_W-1:0]              ptr_q;
  logic [CNT_W-1:0]              count_q;
  logic                          full;
  logic [EXT_W-1:0]              new_base;
  logic [EXT_W-1:0]              new_last;

  assign full     = (count_q == CNT_W'(ENTRIES));
  assign new_base = {1'b0, wr_addr};
  assign new_last = new_base + {{(EXT_W-4){1'b0}}, span_last(wr_size)};
  assign evict_o  = wr_en && full;

  // region storage: one write port, all words read in parallel
  always_ff @(posedge clk) begin
    if (wr_en) begin
      base_q[ptr_q] <= new_base;
      last_q[ptr_q] <= new_last;
    end
  end

  // occupancy and round-robin pointer (oldest entry next to replace)
  always_ff @(posedge clk) begin
    if (rst || clr) begin
      valid_q <= '0;
      ptr_q   <= '0;
      count_q <= '0;
    end else if (wr_en) begin
      valid_q[ptr_q] <= 1'b1;
      ptr_q          <= (ptr_q == PTR_W'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
      if (!full) count_q <= count_q + 1'b1;
    end
  end

  assign valid_o = valid_q;
  assign base_o  = base_q;
  assign last_o  = last_q;

  // R8
  count_bound_chk: assert property (@(posedge clk) disable iff (rst)
    count_q <= CNT_W'(ENTRIES));

  // R8
  valid_count_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(valid_q) == int'(count_q));

  // R6 R7
  clear_empty_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (valid_q == '0));

endmodule

// File: rtl/guard_overlap_cmp.sv
module guard_overlap_cmp #(
  parameter int ENTRIES = 8,
  parameter int EXT_W   = 33
) (
  input  logic [ENTRIES-1:0]             valid_i,
  input  logic [ENTRIES-1:0][EXT_W-1:0]  base_i,
  input  logic [ENTRIES-1:0][EXT_W-1:0]  last_i,
  input  logic [EXT_W-1:0]               q_base,
  input  logic [EXT_W-1:0]               q_last,
  output logic                           hit_o
);

  logic [ENTRIES-1:0] hit_vec;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hit_vec[g] = valid_i[g] &&
                        (base_i[g] <= q_last) &&
                        (q_base <= last_i[g]);
  end

  assign hit_o = |hit_vec;

endmodule

// File: rtl/guard_overflow_flag.sv
module guard_overflow_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic consume_i,
  input  logic clr_i,
  output logic flag_o
);

  logic flag_q;

  always_ff @(posedge clk) begin
    if (rst || clr_i)    flag_q <= 1'b0;
    else if (set_i)      flag_q <= 1'b1;
    else if (consume_i)  flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  // R9
  ovf_set_chk: assert property (@(posedge clk) disable iff (rst)
    (set_i && !clr_i) |=> flag_o);

endmodule

// File: rtl/spec_alias_guard.sv
module spec_alias_guard
  import alias_guard_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int ENTRIES = 8,
  localparam int EXT_W  = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              prot_valid,
  input  logic [ADDR_W-1:0] prot_addr,
  input  logic [1:0]        prot_size,
  input  logic              chk_valid,
  input  logic [ADDR_W-1:0] chk_addr,
  input  logic [1:0]        chk_size,
  input  logic              commit,
  input  logic              rollback,
  output logic              alias_fault
);

  logic                          clr;
  logic                          tbl_wr;
  logic [ENTRIES-1:0]            tbl_valid;
  logic [ENTRIES-1:0][EXT_W-1:0] tbl_base;
  logic [ENTRIES-1:0][EXT_W-1:0] tbl_last;
  logic                          evict;
  logic                          hit;
  logic                          ovf;
  logic [EXT_W-1:0]              st_base;
  logic [EXT_W-1:0]              st_last;
  logic                          fault_q;

  assign clr     = commit || rollback;
  assign tbl_wr  = prot_valid && !clr;
  assign st_base = {1'b0, chk_addr};
  assign st_last = st_base + {{(EXT_W-4){1'b0}}, span_last(chk_size)};

  guard_region_table #(.ADDR_W(ADDR_W), .ENTRIES(ENTRIES)) u_table (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (tbl_wr),
    .wr_addr (prot_addr),
    .wr_size (prot_size),
    .clr     (clr),
    .valid_o (tbl_valid),
    .base_o  (tbl_base),
    .last_o  (tbl_last),
    .evict_o (evict)
  );

  guard_overlap_cmp #(.ENTRIES(ENTRIES), .EXT_W(EXT_W)) u_cmp (
    .valid_i (tbl_valid),
    .base_i  (tbl_base),
    .last_i  (tbl_last),
    .q_base  (st_base),
    .q_last  (st_last),
    .hit_o   (hit)
  );

  guard_overflow_flag u_ovf (
    .clk       (clk),
    .rst       (rst),
    .set_i     (evict),
    .consume_i (chk_valid),
    .clr_i     (clr),
    .flag_o    (ovf)
  );

  always_ff @(posedge clk) begin
    if (rst) fault_q <= 1'b0;
    else     fault_q <= chk_valid && (hit || ovf);
  end

  assign alias_fault = fault_q;

  // R5
  fault_cause_chk: assert property (@(posedge clk) disable iff (rst)
    alias_fault |-> $past(chk_valid));

  // R9
  ovf_force_chk: assert property (@(posedge clk) disable iff (rst)
    (chk_valid && ovf) |=> alias_fault);

endmodule

// File: tb/spec_alias_guard_tb.sv
module spec_alias_guard_tb;

  localparam int CLK_P  = 10;
  localparam int ADDR_W = 32;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              prot_valid = 1'b0;
  logic [ADDR_W-1:0] prot_addr = '0;
  logic [1:0]        prot_size = '0;
  logic              chk_valid = 1'b0;
  logic [ADDR_W-1:0] chk_addr = '0;
  logic [1:0]        chk_size = '0;
  logic              commit = 1'b0;
  logic              rollback = 1'b0;
  logic              alias_fault;

  int checks = 0;
  int failures = 0;
  bit exp_q[$];
  string tag_q[$];

  always #(CLK_P/2) clk = ~clk;

  spec_alias_guard #(.ADDR_W(ADDR_W), .ENTRIES(8)) u_dut (
    .clk(clk), .rst(rst),
    .prot_valid(prot_valid), .prot_addr(prot_addr), .prot_size(prot_size),
    .chk_valid(chk_valid), .chk_addr(chk_addr), .chk_size(chk_size),
    .commit(commit), .rollback(rollback), .alias_fault(alias_fault)
  );

  // monitor: compare the verdict due after each edge
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      bit e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (alias_fault !== e) begin
        failures++;
        $display("FAIL %s alias_fault actual=%b expected=%b", t, alias_fault, e);
      end
    end
  end

  // driver: one request set per cycle, expected verdict queued
  task automatic drv(input bit pv, input logic [ADDR_W-1:0] pa, input logic [1:0] ps,
                     input bit cv, input logic [ADDR_W-1:0] ca, input logic [1:0] cs,
                     input bit cm, input bit rb, input bit exp, input string tag);
    @(negedge clk);
    prot_valid = pv; prot_addr = pa; prot_size = ps;
    chk_valid = cv;  chk_addr = ca;  chk_size = cs;
    commit = cm;     rollback = rb;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
  endtask

  task automatic prot(input logic [ADDR_W-1:0] a, input logic [1:0] s, input string tag);
    drv(1, a, s, 0, '0, 0, 0, 0, 0, tag);
  endtask

  task automatic chk(input logic [ADDR_W-1:0] a, input logic [1:0] s, input bit exp, input string tag);
    drv(0, '0, 0, 1, a, s, 0, 0, exp, tag);
  endtask

  task automatic idle(input string tag);
    drv(0, '0, 0, 0, '0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    #(CLK_P * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (alias_fault !== 1'b0) begin
      failures++;
      $display("FAIL R1 reset alias_fault actual=%b expected=0", alias_fault);
    end
    @(negedge clk);
    rst = 1'b0;

    chk(32'h100, 0, 0, "R1 empty table");
    prot(32'h100, 2, "R2 protect 100..103");
    chk(32'h102, 0, 1, "R3 inside region");
    idle("R3 single pulse");
    chk(32'h0FE, 1, 0, "R4 adjacent below");
    chk(32'h104, 2, 0, "R4 adjacent above");
    chk(32'h0FC, 3, 1, "R3 partial low overlap");
    chk(32'h103, 1, 1, "R3 partial high overlap");
    drv(0, '0, 0, 0, 32'h100, 0, 0, 0, 0, "R5 unchecked store");
    drv(0, '0, 0, 0, '0, 0, 1, 0, 0, "R6 commit");
    chk(32'h100, 0, 0, "R6 cleared by commit");

    prot(32'h200, 3, "R2 protect 200..207");
    chk(32'h207, 0, 1, "R2 last byte of 8");
    chk(32'h208, 0, 0, "R2 past last byte");
    drv(0, '0, 0, 0, '0, 0, 0, 1, 0, "R7 rollback");
    chk(32'h204, 0, 0, "R7 cleared by rollback");

    drv(1, 32'h300, 0, 1, 32'h300, 0, 0, 0, 0, "R10 same cycle protect+store");
    chk(32'h300, 0, 1, "R10 later store sees region");
    drv(0, '0, 0, 1, 32'h300, 0, 1, 0, 1, "R11 store checked before clear");
    chk(32'h300, 0, 0, "R11 table empty after clear");
    drv(1, 32'h400, 0, 0, '0, 0, 1, 0, 0, "R11 protect with commit");
    chk(32'h400, 0, 0, "R11 protect discarded");

    for (int i = 0; i < 8; i++) prot(32'h1000 + 32'(i) * 32'h10, 0, "R8 fill");
    chk(32'h1070, 0, 1, "R8 eighth entry kept");
    chk(32'h1000, 0, 1, "R8 first entry kept");
    chk(32'h2000, 0, 0, "R8 full table no overflow");
    prot(32'h1080, 0, "R9 replace oldest");
    chk(32'h5000, 0, 1, "R9 overflow forces fault");
    chk(32'h5000, 0, 0, "R9 flag consumed");
    chk(32'h1000, 0, 0, "R8 oldest replaced");
    chk(32'h1010, 0, 1, "R8 second entry kept");
    chk(32'h1080, 0, 1, "R8 new entry stored");
    prot(32'h1090, 0, "R9 overflow again");
    drv(0, '0, 0, 0, '0, 0, 0, 1, 0, "R7 rollback clears overflow");
    chk(32'h5000, 0, 0, "R7 no forced fault");

    prot(32'hFFFF_FFFC, 3, "R12 protect at top");
    chk(32'h0, 0, 0, "R12 no wrap to zero");
    chk(32'hFFFF_FFFF, 0, 1, "R12 top byte covered");
    idle("R3 tail idle");

    repeat (3) @(posedge clk);
    #2;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule